// File: doc/BRIEF.md
# DFU Class Request State Machine

This block is the device-side controller for the seven class requests of the USB Device Firmware Upgrade protocol. The control endpoint logic decodes each setup packet and presents the request type byte, the request code and the data length for one cycle on `setup_i`. The block checks that the request is well formed and allowed in the current state. It then moves to the next state and updates the status code. If the request is not allowed, it raises a one-cycle stall pulse for the endpoint logic to turn into a protocol stall.

Three inputs report what the memory side is doing: a level that is high while programming or manifestation is in progress, a pulse with a 4-bit error code when the memory engine fails, and a bus-reset pulse. The block also holds the 6-byte status reply and the 1-byte state reply. The endpoint logic returns these in the data stage of the next status or state request. Packet handling, the flash engine and the parsing of the firmware image are outside this block.

All outputs are registered. The effect of a request or an event shows up in the cycle after the clock edge that samples it.

Top module: `dfu_req_fsm`

## Requirements
- R1: After reset, the state output is appIDLE (0) when START_IN_DFU is 0, the status output is 00h and the stall output is low.
- R2: A request is well formed only if its fields match its code. DETACH (0), CLRSTATUS (4) and ABORT (6) need type 21h and length 0. DNLOAD (1) needs type 21h and a length of at most MAX_XFER. UPLOAD (2) needs type A1h and a length of 1 to MAX_XFER. GETSTATUS (3) needs type A1h and length 6. GETSTATE (5) needs type A1h and length 1. A code of 7 or higher is never well formed.
- R3: In states 2 to 7 and 9, a request that is malformed or not allowed there causes three things in the next cycle: a one-cycle stall pulse, status 0Fh and state dfuERROR (10). Every request is disallowed in dfuDNBUSY (4) and dfuMANIFEST (7).
- R4: In appIDLE (0) and appDETACH (1), only GETSTATUS and GETSTATE are accepted, plus DETACH in appIDLE. In dfuMANIFEST-WAIT-RESET (8), no request is accepted. In these three states a rejected request stalls but leaves the state and status unchanged.
- R5: DETACH in appIDLE moves to appDETACH (1). A bus reset in appDETACH moves to dfuIDLE (2). A bus reset in dfuMANIFEST-WAIT-RESET moves to appIDLE.
- R6: An accepted GETSTATUS sets a 48-bit reply, with byte k at bits 8k+7..8k. Byte 0 is the status. Bytes 1 to 3 are the poll timeout, least significant byte first, equal to POLL_MS when the next state is dfuDNBUSY or dfuMANIFEST and 0 otherwise. Byte 4 is the state entered after the request. Byte 5 is the string index, always 00h.
- R7: An accepted GETSTATE sets the 1-byte reply to the current state and leaves the state and status unchanged.
- R8: dfuERROR is left only through CLRSTATUS, which moves to dfuIDLE with status 00h. Any other rejected request in dfuERROR stalls and keeps the recorded status.
- R9: ABORT in dfuIDLE, dfuDNLOAD-IDLE (5) or dfuUPLOAD-IDLE (9) moves to dfuIDLE with status 00h.
- R10: A DNLOAD with non-zero length in dfuIDLE or dfuDNLOAD-IDLE moves to dfuDNLOAD-SYNC (3). GETSTATUS in dfuDNLOAD-SYNC moves to dfuDNBUSY if `prog_busy_i` is high, and to dfuDNLOAD-IDLE if it is low. dfuDNBUSY moves to dfuDNLOAD-IDLE in the cycle after `prog_busy_i` is seen low, and stays put while it is high.
- R11: A zero-length DNLOAD in dfuDNLOAD-IDLE moves to dfuMANIFEST-SYNC (6) if `all_data_i` is high. If it is low, the block sets status 09h, moves to dfuERROR and does not stall. A zero-length DNLOAD in dfuIDLE is rejected as in R3.
- R12: GETSTATUS in dfuMANIFEST-SYNC moves to dfuMANIFEST (7) if `prog_busy_i` is high, and to dfuMANIFEST-WAIT-RESET if it is low. dfuMANIFEST moves to dfuMANIFEST-WAIT-RESET once `prog_busy_i` is low.
- R13: UPLOAD in dfuIDLE moves to dfuUPLOAD-IDLE. A further UPLOAD there keeps the state.
- R14: Bus reset has priority over the error pulse, and the error pulse has priority over a request in the same cycle. A bus reset in states 3 to 7 or 9 moves to dfuERROR with status 0Ch. An error pulse in states 2 to 7 or 9 moves to dfuERROR with status equal to the zero-extended `err_code_i`. An error pulse in any other state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 1 | One-cycle strobe: a decoded class request is present |
| req_type_i | input | 8 | Request type byte of the setup packet |
| req_code_i | input | 8 | Request code byte of the setup packet |
| req_len_i | input | LEN_W | Data stage length of the setup packet |
| all_data_i | input | 1 | High when the memory side holds the complete image |
| prog_busy_i | input | 1 | High while block programming or manifestation runs |
| err_valid_i | input | 1 | One-cycle pulse: the memory side detected an error |
| err_code_i | input | 4 | Status code that goes with `err_valid_i` |
| bus_reset_i | input | 1 | One-cycle pulse: USB bus reset seen |
| stall_o | output | 1 | One-cycle pulse: stall the current request |
| dfu_state_o | output | 4 | Current state encoding |
| dfu_status_o | output | 8 | Current status code |
| status_reply_o | output | 48 | Reply bytes for the last accepted GETSTATUS |
| state_reply_o | output | 8 | Reply byte for the last accepted GETSTATE |

## Verification
The bench builds the block with POLL_MS set to 7, so a non-zero poll timeout is easy to tell apart in the reply bytes. MAX_XFER and START_IN_DFU keep their defaults of 32 and 0. Starting in appIDLE brings the detach path and the application-side stall rules within reach. The 32-byte limit lets a 40-byte download exercise the length check. The bench drives the busy level through both the download and the manifestation branches. It also reaches dfuERROR in four ways: by a rejected request, by a zero-length download with the image incomplete, by the error pulse and by an unexpected bus reset.

// File: rtl/dfu_pkg.sv
package dfu_pkg;

    typedef enum logic [3:0] {
        ST_APP_IDLE   = 4'd0,
        ST_APP_DETACH = 4'd1,
        ST_IDLE       = 4'd2,
        ST_DN_SYNC    = 4'd3,
        ST_DN_BUSY    = 4'd4,
        ST_DN_IDLE    = 4'd5,
        ST_MAN_SYNC   = 4'd6,
        ST_MAN        = 4'd7,
        ST_MAN_WAIT   = 4'd8,
        ST_UP_IDLE    = 4'd9,
        ST_ERROR      = 4'd10
    } dfu_state_e;

    typedef enum logic [2:0] {
        RQ_DETACH = 3'd0,
        RQ_DNLOAD = 3'd1,
        RQ_UPLOAD = 3'd2,
        RQ_GETSTS = 3'd3,
        RQ_CLRSTS = 3'd4,
        RQ_GETST  = 3'd5,
        RQ_ABORT  = 3'd6,
        RQ_NONE   = 3'd7
    } dfu_req_e;

    localparam logic [7:0] TYPE_H2D = 8'h21;
    localparam logic [7:0] TYPE_D2H = 8'hA1;

    localparam int STS_REPLY_LEN = 6;
    localparam int ST_REPLY_LEN  = 1;

    localparam logic [7:0] STS_OK      = 8'h00;
    localparam logic [7:0] STS_NOTDONE = 8'h09;
    localparam logic [7:0] STS_USBRST  = 8'h0C;
    localparam logic [7:0] STS_STALLED = 8'h0F;

    typedef struct packed {
        dfu_state_e state;
        logic [7:0] status;
        logic       stall;
        logic [7:0] rep_status;
        dfu_state_e rep_state;
        logic [7:0] st_reply;
    } fsm_regs_t;

    // States where a transfer or manifestation is under way (bus reset is unexpected).
    function automatic logic in_transfer(input dfu_state_e s);
        return (s == ST_DN_SYNC) || (s == ST_DN_BUSY) || (s == ST_DN_IDLE) ||
               (s == ST_MAN_SYNC) || (s == ST_MAN) || (s == ST_UP_IDLE);
    endfunction

    // States where the memory side can report an error.
    function automatic logic takes_error(input dfu_state_e s);
        return (s == ST_IDLE) || in_transfer(s);
    endfunction

endpackage

// File: rtl/dfu_req_decode.sv
module dfu_req_decode
    import dfu_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MAX_XFER = 32
) (
    input  logic [7:0]       req_type_i,
    input  logic [7:0]       req_code_i,
    input  logic [LEN_W-1:0] req_len_i,
    output dfu_req_e         kind_o,
    output logic             well_formed_o,
    output logic             len_zero_o
);

    localparam logic [LEN_W-1:0] XFER_LIM = LEN_W'(MAX_XFER);
    localparam logic [LEN_W-1:0] LEN_STS  = LEN_W'(STS_REPLY_LEN);
    localparam logic [LEN_W-1:0] LEN_ST   = LEN_W'(ST_REPLY_LEN);

    logic out_dir, in_dir, fits, zero;

    always_comb begin
        out_dir = (req_type_i == TYPE_H2D);
        in_dir  = (req_type_i == TYPE_D2H);
        zero    = (req_len_i == '0);
        fits    = (req_len_i <= XFER_LIM);
        kind_o        = RQ_NONE;
        well_formed_o = 1'b0;
        case (req_code_i)
            8'd0: begin kind_o = RQ_DETACH; well_formed_o = out_dir && zero; end
            8'd1: begin kind_o = RQ_DNLOAD; well_formed_o = out_dir && fits; end
            8'd2: begin kind_o = RQ_UPLOAD; well_formed_o = in_dir && fits && !zero; end
            8'd3: begin kind_o = RQ_GETSTS; well_formed_o = in_dir && (req_len_i == LEN_STS); end
            8'd4: begin kind_o = RQ_CLRSTS; well_formed_o = out_dir && zero; end
            8'd5: begin kind_o = RQ_GETST;  well_formed_o = in_dir && (req_len_i == LEN_ST); end
            8'd6: begin kind_o = RQ_ABORT;  well_formed_o = out_dir && zero; end
            default: begin kind_o = RQ_NONE; well_formed_o = 1'b0; end
        endcase
        len_zero_o = zero;
    end

endmodule

// File: rtl/dfu_status_pack.sv
module dfu_status_pack
    import dfu_pkg::*;
#(
    parameter int POLL_MS = 5,
    parameter int POLL_W  = 24
) (
    input  logic [7:0]                 status_i,
    input  dfu_state_e                 state_i,
    output logic [8*STS_REPLY_LEN-1:0] reply_o
);

    localparam int POLL_BYTES = POLL_W / 8;

    logic [POLL_W-1:0] poll;
    logic [7:0]        field [STS_REPLY_LEN];

    always_comb begin
        poll = ((state_i == ST_DN_BUSY) || (state_i == ST_MAN)) ? POLL_W'(POLL_MS) : '0;
        field[0] = status_i;
        for (int b = 0; b < POLL_BYTES; b++) begin
            field[1+b] = poll[8*b +: 8];
        end
        field[1+POLL_BYTES] = {4'h0, state_i};
        field[2+POLL_BYTES] = 8'h00;
    end

    for (genvar g = 0; g < STS_REPLY_LEN; g++) begin : g_byte
        assign reply_o[8*g +: 8] = field[g];
    end

endmodule

// File: rtl/dfu_req_fsm.sv
module dfu_req_fsm
    import dfu_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int MAX_XFER     = 32,
    parameter int POLL_MS      = 5,
    parameter bit START_IN_DFU = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             setup_i,
    input  logic [7:0]       req_type_i,
    input  logic [7:0]       req_code_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic             all_data_i,
    input  logic             prog_busy_i,
    input  logic             err_valid_i,
    input  logic [3:0]       err_code_i,
    input  logic             bus_reset_i,
    output logic             stall_o,
    output logic [3:0]       dfu_state_o,
    output logic [7:0]       dfu_status_o,
    output logic [47:0]      status_reply_o,
    output logic [7:0]       state_reply_o
);

    localparam dfu_state_e BOOT_ST = START_IN_DFU ? ST_IDLE : ST_APP_IDLE;

    fsm_regs_t d, q;
    dfu_req_e  kind;
    logic      well_formed, len_zero;
    logic      accept;

    dfu_req_decode #(.LEN_W(LEN_W), .MAX_XFER(MAX_XFER)) u_dec (
        .req_type_i    (req_type_i),
        .req_code_i    (req_code_i),
        .req_len_i     (req_len_i),
        .kind_o        (kind),
        .well_formed_o (well_formed),
        .len_zero_o    (len_zero)
    );

    always_comb begin
        d       = q;
        d.stall = 1'b0;
        accept  = 1'b0;
        if (bus_reset_i) begin
            if (q.state == ST_APP_DETACH) begin
                d.state = ST_IDLE;
            end else if (q.state == ST_MAN_WAIT) begin
                d.state = ST_APP_IDLE;
            end else if (in_transfer(q.state)) begin
                d.state  = ST_ERROR;
                d.status = STS_USBRST;
            end
        end else if (err_valid_i && takes_error(q.state)) begin
            d.state  = ST_ERROR;
            d.status = {4'h0, err_code_i};
        end else begin
            if (q.state == ST_DN_BUSY && !prog_busy_i) d.state = ST_DN_IDLE;
            if (q.state == ST_MAN && !prog_busy_i)     d.state = ST_MAN_WAIT;
            if (setup_i) begin
                if (well_formed && (kind == RQ_GETST) &&
                    !(q.state inside {ST_DN_BUSY, ST_MAN, ST_MAN_WAIT})) begin
                    accept     = 1'b1;
                    d.st_reply = {4'h0, q.state};
                end else if (well_formed) begin
                    unique case (q.state)
                        ST_APP_IDLE: begin
                            if (kind == RQ_DETACH) begin accept = 1'b1; d.state = ST_APP_DETACH; end
                            if (kind == RQ_GETSTS) accept = 1'b1;
                        end
                        ST_APP_DETACH: begin
                            if (kind == RQ_GETSTS) accept = 1'b1;
                        end
                        ST_IDLE: begin
                            if (kind == RQ_DNLOAD && !len_zero) begin accept = 1'b1; d.state = ST_DN_SYNC; end
                            if (kind == RQ_UPLOAD) begin accept = 1'b1; d.state = ST_UP_IDLE; end
                            if (kind == RQ_ABORT)  begin accept = 1'b1; d.status = STS_OK; end
                            if (kind == RQ_GETSTS) accept = 1'b1;
                        end
                        ST_DN_SYNC: begin
                            if (kind == RQ_GETSTS) begin
                                accept  = 1'b1;
                                d.state = prog_busy_i ? ST_DN_BUSY : ST_DN_IDLE;
                            end
                        end
                        ST_DN_IDLE: begin
                            if (kind == RQ_DNLOAD) begin
                                accept = 1'b1;
                                if (!len_zero) begin
                                    d.state = ST_DN_SYNC;
                                end else if (all_data_i) begin
                                    d.state = ST_MAN_SYNC;
                                end else begin
                                    d.state  = ST_ERROR;
                                    d.status = STS_NOTDONE;
                                end
                            end
                            if (kind == RQ_ABORT) begin accept = 1'b1; d.state = ST_IDLE; d.status = STS_OK; end
                            if (kind == RQ_GETSTS) accept = 1'b1;
                        end
                        ST_MAN_SYNC: begin
                            if (kind == RQ_GETSTS) begin
                                accept  = 1'b1;
                                d.state = prog_busy_i ? ST_MAN : ST_MAN_WAIT;
                            end
                        end
                        ST_UP_IDLE: begin
                            if (kind == RQ_UPLOAD) accept = 1'b1;
                            if (kind == RQ_ABORT) begin accept = 1'b1; d.state = ST_IDLE; d.status = STS_OK; end
                            if (kind == RQ_GETSTS) accept = 1'b1;
                        end
                        ST_ERROR: begin
                            if (kind == RQ_CLRSTS) begin accept = 1'b1; d.state = ST_IDLE; d.status = STS_OK; end
                            if (kind == RQ_GETSTS) accept = 1'b1;
                        end
                        default: accept = 1'b0;
                    endcase
                end
                if (accept && kind == RQ_GETSTS) begin
                    d.rep_status = d.status;
                    d.rep_state  = d.state;
                end
                if (!accept) begin
                    d.stall = 1'b1;
                    d.state = q.state;
                    if (!(q.state inside {ST_APP_IDLE, ST_APP_DETACH, ST_MAN_WAIT, ST_ERROR})) begin
                        d.state  = ST_ERROR;
                        d.status = STS_STALLED;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state      <= BOOT_ST;
            q.status     <= STS_OK;
            q.stall      <= 1'b0;
            q.rep_status <= STS_OK;
            q.rep_state  <= BOOT_ST;
            q.st_reply   <= 8'h00;
        end else begin
            q <= d;
        end
    end

    dfu_status_pack #(.POLL_MS(POLL_MS)) u_pack (
        .status_i (q.rep_status),
        .state_i  (q.rep_state),
        .reply_o  (status_reply_o)
    );

    assign stall_o       = q.stall;
    assign dfu_state_o   = q.state;
    assign dfu_status_o  = q.status;
    assign state_reply_o = q.st_reply;

    // R8: the error state holds until a well-formed CLRSTATUS arrives
    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_ERROR && !(setup_i && well_formed && kind == RQ_CLRSTS))
        |=> (dfu_state_o == 4'd10));

    // R8: CLRSTATUS in the error state returns to idle with an OK status
    assert_clr_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_ERROR && setup_i && well_formed && kind == RQ_CLRSTS && !bus_reset_i)
        |=> (dfu_state_o == 4'd2 && dfu_status_o == 8'h00));

    // R3: malformed request in an operating state stalls and records 0Fh
    assert_stall_to_error_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (setup_i && !well_formed && !bus_reset_i && !err_valid_i &&
         (q.state inside {ST_IDLE, ST_DN_SYNC, ST_DN_BUSY, ST_DN_IDLE, ST_MAN_SYNC, ST_MAN, ST_UP_IDLE}))
        |=> (stall_o && dfu_state_o == 4'd10 && dfu_status_o == 8'h0F));

    // R7: GETSTATE reports the current state and keeps it
    assert_getstate_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (setup_i && well_formed && kind == RQ_GETST && !bus_reset_i && !err_valid_i &&
         !(q.state inside {ST_DN_BUSY, ST_MAN, ST_MAN_WAIT}))
        |=> (dfu_state_o == $past(dfu_state_o) && state_reply_o == {4'h0, $past(dfu_state_o)}));

    // R10: busy low in dfuDNBUSY leads to dfuDNLOAD-IDLE
    assert_busy_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_DN_BUSY && !prog_busy_i && !bus_reset_i && !err_valid_i && !setup_i)
        |=> (dfu_state_o == 4'd5));

endmodule

// File: tb/sim_dfu_req_fsm.sv
`timescale 1ns/1ps
module sim_dfu_req_fsm;

    typedef struct {
        logic [3:0]  st;
        logic [7:0]  sts;
        logic        stl;
        logic        chk_rep;
        logic [47:0] rep;
        logic        chk_sr;
        logic [7:0]  sr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup = 1'b0;
    logic [7:0]  rtype = 8'h00;
    logic [7:0]  rcode = 8'h00;
    logic [15:0] rlen = 16'h0;
    logic        all_data = 1'b0;
    logic        prog_busy = 1'b0;
    logic        err_valid = 1'b0;
    logic [3:0]  err_code = 4'h0;
    logic        bus_reset = 1'b0;
    logic        stall;
    logic [3:0]  st;
    logic [7:0]  sts;
    logic [47:0] srep;
    logic [7:0]  strep;

    logic probe = 1'b0;
    logic sb_fire = 1'b0;
    logic done = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    dfu_req_fsm #(.LEN_W(16), .MAX_XFER(32), .POLL_MS(7), .START_IN_DFU(1'b0)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .setup_i(setup), .req_type_i(rtype),
        .req_code_i(rcode), .req_len_i(rlen), .all_data_i(all_data),
        .prog_busy_i(prog_busy), .err_valid_i(err_valid), .err_code_i(err_code),
        .bus_reset_i(bus_reset), .stall_o(stall), .dfu_state_o(st),
        .dfu_status_o(sts), .status_reply_o(srep), .state_reply_o(strep)
    );

    always @(posedge clk) sb_fire <= probe;

    // Monitor: compares outputs one cycle after each stimulus
    always @(negedge clk) begin
        if (sb_fire && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (st !== e.st || sts !== e.sts || stall !== e.stl ||
                (e.chk_rep && srep !== e.rep) || (e.chk_sr && strep !== e.sr)) begin
                n_fail++;
                $display("FAIL %s: state=%0d status=%h stall=%b rep=%h sr=%h expected state=%0d status=%h stall=%b rep=%h sr=%h",
                         e.tag, st, sts, stall, srep, strep, e.st, e.sts, e.stl, e.rep, e.sr);
            end
        end
    end

    function automatic exp_t ex(input logic [3:0] s, input logic [7:0] c, input logic k, input string t);
        exp_t e;
        e.st = s; e.sts = c; e.stl = k; e.chk_rep = 1'b0; e.rep = '0;
        e.chk_sr = 1'b0; e.sr = '0; e.tag = t;
        return e;
    endfunction

    // Reply layout from R6: status, 3-byte poll (LSB first), state, string index
    function automatic logic [47:0] rep_of(input logic [7:0] c, input logic [23:0] poll, input logic [3:0] s);
        return {8'h00, 4'h0, s, poll, c};
    endfunction

    function automatic exp_t exr(input logic [3:0] s, input logic [7:0] c, input logic [47:0] r, input string t);
        exp_t e;
        e = ex(s, c, 1'b0, t);
        e.chk_rep = 1'b1; e.rep = r;
        return e;
    endfunction

    function automatic exp_t exs(input logic [3:0] s, input logic [7:0] c, input logic [7:0] r, input string t);
        exp_t e;
        e = ex(s, c, 1'b0, t);
        e.chk_sr = 1'b1; e.sr = r;
        return e;
    endfunction

    task automatic rq(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l, input exp_t e);
        @(negedge clk);
        setup = 1'b1; rtype = t; rcode = c; rlen = l; probe = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        setup = 1'b0; probe = 1'b0;
    endtask

    task automatic usb_rst(input exp_t e);
        @(negedge clk);
        bus_reset = 1'b1; probe = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        bus_reset = 1'b0; probe = 1'b0;
    endtask

    task automatic mem_err(input logic [3:0] c, input exp_t e);
        @(negedge clk);
        err_valid = 1'b1; err_code = c; probe = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        err_valid = 1'b0; probe = 1'b0;
    endtask

    task automatic busy(input logic b, input exp_t e);
        @(negedge clk);
        prog_busy = b; probe = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        probe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        busy(1'b0, ex(4'd0, 8'h00, 1'b0, "R1 reset state"));
        rq(8'hA1, 8'd5, 16'd1, exs(4'd0, 8'h00, 8'h00, "R7 getstate appidle"));
        rq(8'h21, 8'd1, 16'd8, ex(4'd0, 8'h00, 1'b1, "R4 dnload in app stalls"));
        rq(8'h21, 8'd0, 16'd0, ex(4'd1, 8'h00, 1'b0, "R5 detach"));
        usb_rst(ex(4'd2, 8'h00, 1'b0, "R5 reset in appdetach"));
        rq(8'hA1, 8'd3, 16'd6, exr(4'd2, 8'h00, rep_of(8'h00, 24'd0, 4'd2), "R6 getstatus idle"));
        rq(8'hA1, 8'd3, 16'd5, ex(4'd10, 8'h0F, 1'b1, "R2 getstatus bad length"));
        rq(8'h21, 8'd1, 16'd8, ex(4'd10, 8'h0F, 1'b1, "R8 dnload in error"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'h21, 8'd1, 16'd32, ex(4'd3, 8'h00, 1'b0, "R10 dnload to sync"));
        busy(1'b1, ex(4'd3, 8'h00, 1'b0, "R10 sync holds"));
        rq(8'hA1, 8'd3, 16'd6, exr(4'd4, 8'h00, rep_of(8'h00, 24'd7, 4'd4), "R6 getstatus to dnbusy"));
        busy(1'b1, ex(4'd4, 8'h00, 1'b0, "R10 dnbusy holds while busy"));
        busy(1'b0, ex(4'd5, 8'h00, 1'b0, "R10 dnbusy to dnidle"));
        rq(8'h21, 8'd1, 16'd0, ex(4'd10, 8'h09, 1'b0, "R11 zero length incomplete"));
        rq(8'hA1, 8'd3, 16'd6, exr(4'd10, 8'h09, rep_of(8'h09, 24'd0, 4'd10), "R6 getstatus in error"));
        rq(8'h21, 8'd6, 16'd0, ex(4'd10, 8'h09, 1'b1, "R8 abort in error keeps status"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'h21, 8'd1, 16'd0, ex(4'd10, 8'h0F, 1'b1, "R11 zero length in idle"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'h21, 8'd1, 16'd40, ex(4'd10, 8'h0F, 1'b1, "R2 dnload too long"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'h21, 8'd1, 16'd16, ex(4'd3, 8'h00, 1'b0, "R10 dnload"));
        rq(8'hA1, 8'd3, 16'd6, exr(4'd5, 8'h00, rep_of(8'h00, 24'd0, 4'd5), "R10 getstatus not busy"));
        mem_err(4'h3, ex(4'd10, 8'h03, 1'b0, "R14 error pulse"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'h21, 8'd1, 16'd8, ex(4'd3, 8'h00, 1'b0, "R10 dnload"));
        busy(1'b1, ex(4'd3, 8'h00, 1'b0, "R10 sync holds"));
        rq(8'hA1, 8'd3, 16'd6, ex(4'd4, 8'h00, 1'b0, "R10 to dnbusy"));
        rq(8'hA1, 8'd5, 16'd1, ex(4'd10, 8'h0F, 1'b1, "R3 getstate in dnbusy"));
        busy(1'b0, ex(4'd10, 8'h0F, 1'b0, "R8 error ignores busy"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'h21, 8'd1, 16'd8, ex(4'd3, 8'h00, 1'b0, "R10 dnload"));
        rq(8'hA1, 8'd3, 16'd6, ex(4'd5, 8'h00, 1'b0, "R10 to dnidle"));
        all_data = 1'b1;
        rq(8'h21, 8'd1, 16'd0, ex(4'd6, 8'h00, 1'b0, "R11 zero length complete"));
        busy(1'b1, ex(4'd6, 8'h00, 1'b0, "R12 manifest sync holds"));
        rq(8'hA1, 8'd3, 16'd6, exr(4'd7, 8'h00, rep_of(8'h00, 24'd7, 4'd7), "R12 getstatus to manifest"));
        busy(1'b0, ex(4'd8, 8'h00, 1'b0, "R12 manifest to waitreset"));
        rq(8'hA1, 8'd5, 16'd1, ex(4'd8, 8'h00, 1'b1, "R4 getstate in waitreset"));
        usb_rst(ex(4'd0, 8'h00, 1'b0, "R5 reset in waitreset"));
        all_data = 1'b0;
        rq(8'h21, 8'd0, 16'd0, ex(4'd1, 8'h00, 1'b0, "R5 detach"));
        usb_rst(ex(4'd2, 8'h00, 1'b0, "R5 reset in appdetach"));
        rq(8'hA1, 8'd2, 16'd32, ex(4'd9, 8'h00, 1'b0, "R13 upload"));
        rq(8'hA1, 8'd2, 16'd32, ex(4'd9, 8'h00, 1'b0, "R13 upload again"));
        rq(8'h21, 8'd6, 16'd0, ex(4'd2, 8'h00, 1'b0, "R9 abort upload"));
        rq(8'hA1, 8'd2, 16'd4, ex(4'd9, 8'h00, 1'b0, "R13 upload"));
        usb_rst(ex(4'd10, 8'h0C, 1'b0, "R14 reset during upload"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'hA1, 8'd7, 16'd0, ex(4'd10, 8'h0F, 1'b1, "R2 unknown code"));
        rq(8'hA1, 8'd5, 16'd1, exs(4'd10, 8'h0F, 8'h0A, "R7 getstate in error"));
        rq(8'h21, 8'd4, 16'd0, ex(4'd2, 8'h00, 1'b0, "R8 clrstatus"));
        rq(8'h21, 8'd1, 16'd8, ex(4'd3, 8'h00, 1'b0, "R10 dnload"));
        rq(8'hA1, 8'd3, 16'd6, ex(4'd5, 8'h00, 1'b0, "R10 to dnidle"));
        rq(8'h21, 8'd6, 16'd0, ex(4'd2, 8'h00, 1'b0, "R9 abort download"));
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule